// File: doc/BRIEF.md
# Multiply, divide and decimal-adjust unit

This block is the slow-arithmetic helper of a small 8-bit coprocessor whose register file holds an accumulator A, index X, index Y and a five-bit flag set (N, V, H, Z, C). It performs four operations. It multiplies Y by A into the 16-bit Y:A pair. It divides the Y:A pair by X. It applies a decimal correction to A after a binary addition, or after a binary subtraction. The sequencer that owns the register file raises a one-cycle start strobe. With that strobe it presents the operation code, the current A, X and Y and the current flags.

The unit takes the operands in the start cycle and runs for a fixed number of cycles that depends on the operation. It then raises done for one cycle and presents the new A, Y and flags, which the sequencer writes back. The outputs keep their values until the next done. A start that arrives while an operation is in flight is dropped. The divide follows the legacy behaviour of the coprocessor and does not follow textbook arithmetic when the true quotient does not fit in 9 bits. Multiply and divide derive N and Z from one result byte only.

Top module: `mdu_top`

## Requirements
- R1: Operation code 0 (multiply) returns the 16-bit product Y*A, with the low byte on a_out and the high byte on y_out.
- R2: After a multiply, N is bit 7 of the new Y and Z is set exactly when the new Y is zero; V, H and C pass through from flags_in. The flags bus is ordered {N,V,H,Z,C}, with N at bit 4 and C at bit 0.
- R3: Operation code 1 (divide) sets V when Y >= X, sets H when the low nibble of Y >= the low nibble of X, and passes C through.
- R4: When Y < 2*X, the divide returns the low 8 bits of (Y:A)/X on a_out and (Y:A) mod X on y_out.
- R5: When Y >= 2*X (X = 0 included), with E = Y:A - 512*X and D = 256 - X, the divide returns a_out = (255 - E/D) mod 256 and y_out = (X + E mod D) mod 256.
- R6: After a divide, N is bit 7 of the new A and Z is set exactly when the new A is zero.
- R7: Operation code 2 (adjust after add) first adds 0x60 to A and sets C when C is set or A > 0x99. It then adds 0x06 when H is set or the low nibble of the partial result is above 9. N and Z follow the final A, and V, H and Y pass through.
- R8: Operation code 3 (adjust after subtract) first subtracts 0x60 from A and clears C when C is clear or A > 0x99. It then subtracts 0x06 when H is clear or the low nibble is above 9. N and Z follow the final A, and V, H and Y pass through.
- R9: done is high for exactly one cycle, 8 clock edges after the edge that samples start for a multiply, 11 for a divide and 2 for either adjust; busy is high from the edge after start until that done edge.
- R10: A start that is sampled while busy is high is ignored and does not change the operation in flight or its result.
- R11: After reset, done and busy are low and a_out, y_out and flags_out are zero; the outputs change only in the cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| op_sel | input | 2 | 0 multiply, 1 divide, 2 adjust after add, 3 adjust after subtract |
| a_in | input | 8 | Current A |
| x_in | input | 8 | Current X |
| y_in | input | 8 | Current Y |
| flags_in | input | 5 | Current flags {N,V,H,Z,C} |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| a_out | output | 8 | New A |
| y_out | output | 8 | New Y |
| flags_out | output | 5 | New flags {N,V,H,Z,C} |

## Verification
The hardest area to reach is the overflowed divide, where Y is at least twice X. Random operands rarely land on X = 0, on X near 255, or on a remainder that wraps past 8 bits. The stimulus therefore contains directed divides with a zero divisor, with Y far above 2*X and with Y exactly 2*X, plus a random phase that biases X toward small values. A second situation that is hard to reach is a start strobe that lands mid-operation. The bench fires one deliberately a few cycles into a divide and also lets random back-to-back requests collide with the done edge.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    localparam int DW = 8;

    typedef enum logic [1:0] {
        OP_MUL  = 2'd0,
        OP_DIV  = 2'd1,
        OP_DADD = 2'd2,
        OP_DSUB = 2'd3
    } mdu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic h;
        logic z;
        logic c;
    } mdu_flags_t;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] y;
        mdu_flags_t    f;
    } mdu_res_t;
endpackage

// File: rtl/mdu_mul.sv
module mdu_mul
    import mdu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] y_i,
    input  mdu_flags_t    f_i,
    output mdu_res_t      res_o
);
    logic [2*DW-1:0] prod;

    always_comb begin
        prod       = {{DW{1'b0}}, y_i} * {{DW{1'b0}}, a_i};
        res_o.a    = prod[DW-1:0];
        res_o.y    = prod[2*DW-1:DW];
        res_o.f    = f_i;
        res_o.f.n  = prod[2*DW-1];
        res_o.f.z  = (prod[2*DW-1:DW] == '0);
    end
endmodule

// File: rtl/mdu_div.sv
module mdu_div
    import mdu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] y_i,
    input  mdu_flags_t    f_i,
    output mdu_res_t      res_o
);
    localparam int EW = 2*DW + 1;

    logic [2*DW-1:0] dividend;
    logic [2*DW-1:0] safe_x;
    logic            fits;
    logic [EW-1:0]   excess;
    logic [EW-1:0]   span;
    logic [DW-1:0]   q_sel;
    logic [DW-1:0]   r_sel;

    always_comb begin
        dividend = {y_i, a_i};
        fits     = {1'b0, y_i} < {x_i, 1'b0};
        safe_x   = (x_i == '0) ? 16'(1) : {{DW{1'b0}}, x_i};
        excess   = {1'b0, dividend} - {x_i, {(DW+1){1'b0}}};
        span     = EW'(1 << DW) - {{(DW+1){1'b0}}, x_i};
        if (fits) begin
            q_sel = DW'(dividend / safe_x);
            r_sel = DW'(dividend % safe_x);
        end else begin
            q_sel = DW'(EW'((1 << DW) - 1) - excess / span);
            r_sel = DW'({{(DW+1){1'b0}}, x_i} + excess % span);
        end
        res_o.a   = q_sel;
        res_o.y   = r_sel;
        res_o.f   = f_i;
        res_o.f.v = (y_i >= x_i);
        res_o.f.h = (y_i[3:0] >= x_i[3:0]);
        res_o.f.n = q_sel[DW-1];
        res_o.f.z = (q_sel == '0);
    end
endmodule

// File: rtl/mdu_decadj.sv
module mdu_decadj
    import mdu_pkg::*;
(
    input  logic          sub_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] y_i,
    input  mdu_flags_t    f_i,
    output mdu_res_t      res_o
);
    logic [DW-1:0] acc;
    logic          carry;

    always_comb begin
        acc   = a_i;
        carry = f_i.c;
        if (!sub_i) begin
            if (f_i.c || a_i > 8'h99) begin
                acc   = acc + 8'h60;
                carry = 1'b1;
            end
            if (f_i.h || acc[3:0] > 4'd9) acc = acc + 8'h06;
        end else begin
            if (!f_i.c || a_i > 8'h99) begin
                acc   = acc - 8'h60;
                carry = 1'b0;
            end
            if (!f_i.h || acc[3:0] > 4'd9) acc = acc - 8'h06;
        end
        res_o.a   = acc;
        res_o.y   = y_i;
        res_o.f   = f_i;
        res_o.f.c = carry;
        res_o.f.n = acc[DW-1];
        res_o.f.z = (acc == '0);
    end
endmodule

// File: rtl/mdu_top.sv
module mdu_top
    import mdu_pkg::*;
#(
    parameter int MUL_CYC = 8,
    parameter int DIV_CYC = 11,
    parameter int ADJ_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] op_sel,
    input  logic [7:0] a_in,
    input  logic [7:0] x_in,
    input  logic [7:0] y_in,
    input  logic [4:0] flags_in,
    output logic       busy,
    output logic       done,
    output logic [7:0] a_out,
    output logic [7:0] y_out,
    output logic [4:0] flags_out
);
    localparam int MAX_CYC = (MUL_CYC > DIV_CYC) ?
                             ((MUL_CYC > ADJ_CYC) ? MUL_CYC : ADJ_CYC) :
                             ((DIV_CYC > ADJ_CYC) ? DIV_CYC : ADJ_CYC);
    localparam int CW = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        mdu_op_e       op;
        mdu_res_t      pend;
        mdu_res_t      outr;
    } state_t;

    state_t     st_d, st_q;
    mdu_op_e    op_req;
    mdu_flags_t f_req;
    mdu_res_t   mul_res, div_res, adj_res, sel_res;

    assign op_req = mdu_op_e'(op_sel);
    assign f_req  = mdu_flags_t'(flags_in);

    mdu_mul u_mul (.a_i(a_in), .y_i(y_in), .f_i(f_req), .res_o(mul_res));
    mdu_div u_div (.a_i(a_in), .x_i(x_in), .y_i(y_in), .f_i(f_req), .res_o(div_res));
    mdu_decadj u_adj (.sub_i(op_sel[0]), .a_i(a_in), .y_i(y_in), .f_i(f_req),
                      .res_o(adj_res));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (op_req)
            OP_MUL:  sel_res = mul_res;
            OP_DIV:  sel_res = div_res;
            default: sel_res = adj_res;
        endcase
        if (st_q.busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.outr = st_q.pend;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.op   = op_req;
            st_d.pend = sel_res;
            unique case (op_req)
                OP_MUL:  st_d.cnt = CW'(MUL_CYC);
                OP_DIV:  st_d.cnt = CW'(DIV_CYC);
                default: st_d.cnt = CW'(ADJ_CYC);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign a_out     = st_q.outr.a;
    assign y_out     = st_q.outr.y;
    assign flags_out = st_q.outr.f;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (a_out == $past(a_out) && y_out == $past(y_out)
                   && flags_out == $past(flags_out)));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (st_q.op == $past(st_q.op)
                             && st_q.pend == $past(st_q.pend)));

    // R2
    mul_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.op == OP_MUL) |->
            (flags_out[4] == y_out[7] && flags_out[1] == (y_out == 8'h00)));

    // R6
    div_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.op == OP_DIV) |->
            (flags_out[4] == a_out[7] && flags_out[1] == (a_out == 8'h00)));
endmodule

// File: tb/sim_mdu_top.sv
module sim_mdu_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] op_sel = 2'd0;
    logic [7:0] a_in = 8'h00, x_in = 8'h00, y_in = 8'h00;
    logic [4:0] flags_in = 5'h00;
    logic       busy, done;
    logic [7:0] a_out, y_out;
    logic [4:0] flags_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    mdu_top u0 (.clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
                .a_in(a_in), .x_in(x_in), .y_in(y_in), .flags_in(flags_in),
                .busy(busy), .done(done), .a_out(a_out), .y_out(y_out),
                .flags_out(flags_out));

    // reference: returns {a, y, flags}
    function automatic logic [20:0] ref_op(input int op, input int a, input int x,
                                           input int y, input logic [4:0] f);
        int ra, ry, ya, e, d, p;
        logic n, v, h, z, c;
        {n, v, h, z, c} = f;
        ra = a; ry = y;
        case (op)
            0: begin
                p = a * y; ra = p % 256; ry = p / 256;
                n = (ry >= 128); z = (ry == 0);
            end
            1: begin
                ya = y * 256 + a;
                v = (y >= x); h = ((y % 16) >= (x % 16));
                if (y < 2 * x) begin ra = (ya / x) % 256; ry = ya % x; end
                else begin
                    e = ya - 512 * x; d = 256 - x;
                    ra = (255 - e / d) % 256; ry = (x + e % d) % 256;
                end
                n = (ra >= 128); z = (ra == 0);
            end
            2: begin
                if (c || ra > 153) begin ra = (ra + 96) % 256; c = 1'b1; end
                if (h || (ra % 16) > 9) ra = (ra + 6) % 256;
                n = (ra >= 128); z = (ra == 0);
            end
            default: begin
                if (!c || ra > 153) begin ra = (ra + 256 - 96) % 256; c = 1'b0; end
                if (!h || (ra % 16) > 9) ra = (ra + 256 - 6) % 256;
                n = (ra >= 128); z = (ra == 0);
            end
        endcase
        return {ra[7:0], ry[7:0], n, v, h, z, c};
    endfunction

    function automatic int lat_of(input int op);
        return (op == 0) ? 8 : (op == 1) ? 11 : 2;
    endfunction

    // cycle model
    logic        m_busy = 1'b0, m_done = 1'b0;
    int          m_cnt = 0, m_op = 0;
    logic [20:0] m_pend = '0, m_out = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_cnt = 0; m_out = '0; m_pend = '0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin m_busy = 1'b0; m_done = 1'b1; m_out = m_pend; end
            end else if (start) begin
                m_op = op_sel; m_busy = 1'b1; m_cnt = lat_of(op_sel);
                m_pend = ref_op(op_sel, a_in, x_in, y_in, flags_in);
            end
        end
    end

    function automatic string tag_of(input int op);
        return (op == 0) ? "R1/R2" : (op == 1) ? "R3-R6" : (op == 2) ? "R7" : "R8";
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            n_checks++;
            if ({busy, done} !== {m_busy, m_done}) begin
                n_fails++;
                $display("FAIL R9/R10 busy,done actual=%b%b expected=%b%b",
                         busy, done, m_busy, m_done);
            end
            n_checks++;
            if ({a_out, y_out, flags_out} !== m_out) begin
                n_fails++;
                $display("FAIL %s/R11 outputs actual=%h expected=%h",
                         tag_of(m_op), {a_out, y_out, flags_out}, m_out);
            end
        end
    end

    task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one op, wait for done, check latency and the given values
    task automatic run_op(input int op, input logic [7:0] a, input logic [7:0] x,
                          input logic [7:0] y, input logic [4:0] f,
                          input string req, input logic [20:0] exp);
        int waited = 0;
        @(negedge clk);
        start = 1'b1; op_sel = op[1:0]; a_in = a; x_in = x; y_in = y; flags_in = f;
        @(negedge clk);
        start = 1'b0; waited = 1;
        while (!done && waited < 20) begin @(negedge clk); waited++; end
        // R9: done seen L+1 negedges after the drive
        check("R9", 21'(waited), 21'(lat_of(op) + 1));
        check(req, {a_out, y_out, flags_out}, exp);
    endtask

    initial begin
        #1_000_000;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", {a_out, y_out, flags_out, busy, done} , '0);
        rst_n = 1'b1;
        // R1 R2
        run_op(0, 8'h12, 8'h00, 8'h34, 5'b01101, "R1", {8'hA8, 8'h03, 5'b01101});
        run_op(0, 8'h80, 8'h00, 8'hFF, 5'b00000, "R2", {8'h80, 8'h7F, 5'b00000});
        run_op(0, 8'h00, 8'h00, 8'h80, 5'b10000, "R2", {8'h00, 8'h00, 5'b00010});
        // R3 R4 R6
        run_op(1, 8'h23, 8'h10, 8'h01, 5'b00001, "R4", {8'h12, 8'h03, 5'b00101});
        // R5 overflow, R3 V set
        run_op(1, 8'h00, 8'h10, 8'h30, 5'b00000, "R5", {8'hEE, 8'h20, 5'b11100});
        // R5 zero divisor
        run_op(1, 8'h77, 8'h00, 8'h05, 5'b00000, "R5", {8'hFA, 8'h77, 5'b11100});
        // R5 boundary Y == 2X
        run_op(1, 8'h00, 8'h40, 8'h80, 5'b00000, "R5",
               ref_op(1, 8'h00, 8'h40, 8'h80, 5'b00000));
        // R7
        run_op(2, 8'h9A, 8'h00, 8'h55, 5'b00000, "R7", {8'h00, 8'h55, 5'b00011});
        run_op(2, 8'h15, 8'h00, 8'h00, 5'b00100, "R7", {8'h1B, 8'h00, 5'b00100});
        // R8
        run_op(3, 8'h3F, 8'h00, 8'h00, 5'b00101, "R8", {8'h39, 8'h00, 5'b00101});
        run_op(3, 8'h20, 8'h00, 8'h00, 5'b00000, "R8", {8'hBA, 8'h00, 5'b10000});
        // R10: start during a divide is dropped
        @(negedge clk);
        start = 1'b1; op_sel = 2'd1; a_in = 8'h23; x_in = 8'h10; y_in = 8'h01; flags_in = 5'h00;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; op_sel = 2'd0; a_in = 8'hFF; y_in = 8'hFF;
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        check("R10", {a_out, y_out, flags_out}, {8'h12, 8'h03, 5'b00100});
        repeat (12) @(negedge clk);
        check("R10", 21'(done), 21'(0));
        // random back-to-back, model compared each cycle
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            start    = ($urandom_range(0, 3) != 0);
            op_sel   = 2'($urandom_range(0, 3));
            a_in     = 8'($urandom);
            x_in     = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 4)) : 8'($urandom);
            y_in     = 8'($urandom);
            flags_in = 5'($urandom);
        end
        @(negedge clk); start = 1'b0;
        repeat (15) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule